// File: doc/BRIEF.md
# Packet-to-Flit Serializer with End-of-Packet Handshake

This block takes one packet from an upstream stage over a four-phase request/acknowledge handshake. It sends the packet downstream as a fixed number of narrow flits, also over a four-phase handshake. Once the last data flit has been acknowledged, a separate end-of-packet wire carries out one more complete four-phase handshake with the same downstream acknowledge. Only after that does the block acknowledge the upstream packet.

The controller is a chain of identical stage sequencers, one per data flit plus one for end-of-packet. At any time at most one stage holds the token. The token drives a one-hot multiplexer that picks the flit out of a captured packet register, so no shift register is used. The downstream data request is the OR of the data stage controls, and the last stage control is the end-of-packet request. The design is clocked: it samples the handshake wires on each rising edge.

Top module: `flit_serializer`

## Requirements
- R1: While reset is asserted, and after it, `up_ack`, `fl_req` and `fl_eop` are 0 and `fl_data` is 0.
- R2: `up_data` is registered on the edge that first samples `up_req` high while the block is idle. Changes on `up_data` after that edge do not alter any flit of that packet.
- R3: Flit k carries packet bits [2k+1:2k] (k = 0, 1, 2). Flits are sent in ascending k.
- R4: `fl_data` shows flit k at least one cycle before `fl_req` rises for it, and stays unchanged while `fl_req` is high.
- R5: A downstream request (`fl_req` or `fl_eop`) stays high until `fl_ack` is sampled high. It falls on the next edge and stays low for as long as `fl_ack` stays high.
- R6: The first request of a packet rises on the second edge after `up_req` is sampled high. Each later request rises on the second edge after `fl_ack` is sampled low.
- R7: Each packet produces exactly three `fl_req` handshakes followed by one `fl_eop` handshake. `fl_req` and `fl_eop` are never high together.
- R8: `up_ack` stays low until the end-of-packet handshake is done. It rises on the edge that samples `fl_ack` low after `fl_eop` has fallen.
- R9: `up_ack` stays high while `up_req` stays high, and falls on the edge that samples `up_req` low. No downstream request is raised while `up_ack` is high.
- R10: `fl_ack` pulses while the block is idle have no effect on `fl_req`, `fl_eop` or `up_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Upstream packet request |
| up_data | input | 6 | Upstream packet |
| up_ack | output | 1 | Upstream acknowledge |
| fl_req | output | 1 | Downstream data-flit request |
| fl_eop | output | 1 | Downstream end-of-packet request |
| fl_data | output | 2 | Downstream flit data |
| fl_ack | input | 1 | Shared downstream acknowledge |

## Verification
Every result has a fixed latency counted from the edge that samples its stimulus:
- the first request appears two edges after `up_req` rises;
- a request drops one edge after `fl_ack` is sampled high;
- the next request rises two edges after `fl_ack` is sampled low;
- `up_ack` changes on the edge that samples its trigger.

The bench drives inputs on falling edges and reads outputs on the falling edges at exactly those offsets. It also checks the intervening falling edge, where a request must still be low while the next flit is already on the data wires. The acknowledge hold times vary from packet to packet, which shows that each stage waits on the acknowledge level and not on a fixed count.

// File: rtl/fser_pkg.sv
package fser_pkg;

    localparam int unsigned DEF_FLIT_W    = 2;
    localparam int unsigned DEF_NUM_FLITS = 3;

    typedef enum logic [1:0] {
        STG_IDLE  = 2'd0,
        STG_SETUP = 2'd1,
        STG_REQ   = 2'd2,
        STG_REL   = 2'd3
    } stage_state_e;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_BUSY = 2'd1,
        PK_ACK  = 2'd2
    } pkt_state_e;

    typedef struct packed {
        logic token;
        logic ctrl;
        logic done;
    } stage_out_t;

endpackage

// File: rtl/fser_stage.sv
module fser_stage
    import fser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       ack,
    output stage_out_t sout
);

    stage_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STG_IDLE;
        end else begin
            unique case (state_q)
                STG_IDLE:  if (start) state_q <= STG_SETUP;
                STG_SETUP: state_q <= STG_REQ;
                STG_REQ:   if (ack) state_q <= STG_REL;
                STG_REL:   if (!ack) state_q <= STG_IDLE;
                default:   state_q <= STG_IDLE;
            endcase
        end
    end

    always_comb begin
        sout.token = (state_q != STG_IDLE);
        sout.ctrl  = (state_q == STG_REQ);
        sout.done  = (state_q == STG_REL) && !ack;
    end

    // R6: a stage is never started while it still holds the token
    a_r6_start_when_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> (state_q == STG_IDLE));

endmodule

// File: rtl/fser_chain.sv
module fser_chain
    import fser_pkg::*;
#(
    parameter int unsigned NUM_STAGES = DEF_NUM_FLITS + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  launch,
    input  logic                  ack,
    output logic [NUM_STAGES-1:0] sel,
    output logic [NUM_STAGES-1:0] ctrl,
    output logic                  finish
);

    stage_out_t             so   [NUM_STAGES];
    logic [NUM_STAGES-1:0]  done;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        logic kick;
        if (i == 0) begin : g_first
            assign kick = launch;
        end else begin : g_next
            assign kick = done[i-1];
        end

        fser_stage u_stage (
            .clk   (clk),
            .rst   (rst),
            .start (kick),
            .ack   (ack),
            .sout  (so[i])
        );

        assign sel[i]  = so[i].token;
        assign ctrl[i] = so[i].ctrl;
        assign done[i] = so[i].done;
    end

    assign finish = done[NUM_STAGES-1];

    // R7: at most one stage owns the token
    a_r7_onehot_token: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R7: at most one stage control is high
    a_r7_onehot_ctrl: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctrl));

endmodule

// File: rtl/fser_capture.sv
module fser_capture
    import fser_pkg::*;
#(
    parameter int unsigned PKT_W = DEF_FLIT_W * DEF_NUM_FLITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_req,
    input  logic [PKT_W-1:0] up_data,
    input  logic             finish,
    output logic [PKT_W-1:0] pkt_q,
    output logic             launch,
    output logic             up_ack
);

    pkt_state_e state_q;

    assign launch = (state_q == PK_IDLE) && up_req;
    assign up_ack = (state_q == PK_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PK_IDLE;
            pkt_q   <= '0;
        end else begin
            unique case (state_q)
                PK_IDLE: begin
                    if (up_req) begin
                        pkt_q   <= up_data;
                        state_q <= PK_BUSY;
                    end
                end
                PK_BUSY: if (finish) state_q <= PK_ACK;
                PK_ACK:  if (!up_req) state_q <= PK_IDLE;
                default: state_q <= PK_IDLE;
            endcase
        end
    end

    // R2: the captured packet is frozen while a packet is in flight
    a_r2_hold_packet: assert property (@(posedge clk) disable iff (rst)
        (state_q != PK_IDLE) |=> $stable(pkt_q));

    // R9: acknowledge held while the upstream request stays high
    a_r9_ack_held: assert property (@(posedge clk) disable iff (rst)
        (up_ack && up_req) |=> up_ack);

    // R9: acknowledge released once the request is seen low
    a_r9_ack_release: assert property (@(posedge clk) disable iff (rst)
        (up_ack && !up_req) |=> !up_ack);

endmodule

// File: rtl/fser_mux.sv
module fser_mux
    import fser_pkg::*;
#(
    parameter int unsigned FLIT_W    = DEF_FLIT_W,
    parameter int unsigned NUM_FLITS = DEF_NUM_FLITS,
    localparam int unsigned PKT_W    = FLIT_W * NUM_FLITS
) (
    input  logic [PKT_W-1:0]   pkt,
    input  logic [NUM_FLITS:0] sel,
    input  logic [NUM_FLITS:0] ctrl,
    output logic [FLIT_W-1:0]  flit,
    output logic               req,
    output logic               eop
);

    logic [FLIT_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NUM_FLITS; i++) begin
            if (sel[i]) acc = acc | pkt[i*FLIT_W +: FLIT_W];
        end
        flit = sel[NUM_FLITS] ? '0 : acc;
        req  = |ctrl[NUM_FLITS-1:0];
        eop  = ctrl[NUM_FLITS];
    end

endmodule

// File: rtl/flit_serializer.sv
module flit_serializer
    import fser_pkg::*;
#(
    parameter int unsigned FLIT_W    = DEF_FLIT_W,
    parameter int unsigned NUM_FLITS = DEF_NUM_FLITS,
    localparam int unsigned PKT_W      = FLIT_W * NUM_FLITS,
    localparam int unsigned NUM_STAGES = NUM_FLITS + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_req,
    input  logic [PKT_W-1:0]  up_data,
    output logic              up_ack,
    output logic              fl_req,
    output logic              fl_eop,
    output logic [FLIT_W-1:0] fl_data,
    input  logic              fl_ack
);

    logic [PKT_W-1:0]      pkt_q;
    logic                  launch;
    logic                  finish;
    logic [NUM_STAGES-1:0] sel;
    logic [NUM_STAGES-1:0] ctrl;

    fser_capture #(.PKT_W(PKT_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .up_req  (up_req),
        .up_data (up_data),
        .finish  (finish),
        .pkt_q   (pkt_q),
        .launch  (launch),
        .up_ack  (up_ack)
    );

    fser_chain #(.NUM_STAGES(NUM_STAGES)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .ack    (fl_ack),
        .sel    (sel),
        .ctrl   (ctrl),
        .finish (finish)
    );

    fser_mux #(.FLIT_W(FLIT_W), .NUM_FLITS(NUM_FLITS)) u_mux (
        .pkt  (pkt_q),
        .sel  (sel),
        .ctrl (ctrl),
        .flit (fl_data),
        .req  (fl_req),
        .eop  (fl_eop)
    );

    // R7: data request and end-of-packet request are exclusive
    a_r7_req_eop_excl: assert property (@(posedge clk) disable iff (rst)
        !(fl_req && fl_eop));

    // R5: a data request falls on the edge after the acknowledge is seen
    a_r5_req_drop: assert property (@(posedge clk) disable iff (rst)
        (fl_req && fl_ack) |=> !fl_req);

    // R5: the end-of-packet request falls likewise
    a_r5_eop_drop: assert property (@(posedge clk) disable iff (rst)
        (fl_eop && fl_ack) |=> !fl_eop);

    // R4: flit data is steady while a data request is high
    a_r4_data_stable: assert property (@(posedge clk) disable iff (rst)
        fl_req |-> $stable(fl_data));

    // R9: no downstream request while the upstream acknowledge is high
    a_r9_quiet_on_ack: assert property (@(posedge clk) disable iff (rst)
        up_ack |-> (!fl_req && !fl_eop));

endmodule

// File: tb/test_flit_serializer.sv
module test_flit_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up_req = 1'b0;
    logic [5:0] up_data = '0;
    logic       up_ack;
    logic       fl_req;
    logic       fl_eop;
    logic [1:0] fl_data;
    logic       fl_ack = 1'b0;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flit_serializer i_flit_serializer (
        .clk     (clk),
        .rst     (rst),
        .up_req  (up_req),
        .up_data (up_data),
        .up_ack  (up_ack),
        .fl_req  (fl_req),
        .fl_eop  (fl_eop),
        .fl_data (fl_data),
        .fl_ack  (fl_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(up_ack == 0, "R1", "up_ack in reset", int'(up_ack), 0);
        chk(fl_req == 0 && fl_eop == 0, "R1", "requests in reset",
            int'({fl_req, fl_eop}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(fl_data == 0, "R1", "fl_data after reset", int'(fl_data), 0);
        chk(up_ack == 0 && fl_req == 0 && fl_eop == 0, "R1", "outputs after reset",
            int'({up_ack, fl_req, fl_eop}), 0);
    endtask

    task automatic test_idle_ack();
        for (int n = 0; n < 3; n++) begin
            fl_ack = 1'b1;
            @(negedge clk);
            fl_ack = 1'b0;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk(fl_req == 0 && fl_eop == 0 && up_ack == 0, "R10", "idle ack ignored",
            int'({up_ack, fl_req, fl_eop}), 0);
    endtask

    task automatic send_packet(input logic [5:0] d, input int hold);
        up_req  = 1'b1;
        up_data = d;
        @(negedge clk);
        chk(fl_req == 0, "R6", "first request too early", int'(fl_req), 0);
        chk(fl_data == d[1:0], "R4", "flit 0 ahead of request", int'(fl_data), int'(d[1:0]));
        up_data = ~d;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            if (k < 3) begin
                chk(fl_req == 1 && fl_eop == 0, "R6", $sformatf("flit %0d request", k),
                    int'({fl_req, fl_eop}), 2);
                chk(fl_data == 2'((d >> (2*k)) & 6'h3), "R3",
                    $sformatf("flit %0d data (R2 capture)", k),
                    int'(fl_data), int'((d >> (2*k)) & 6'h3));
            end else begin
                chk(fl_eop == 1 && fl_req == 0, "R7", "eop request",
                    int'({fl_req, fl_eop}), 1);
            end
            chk(up_ack == 0, "R8", "up_ack early", int'(up_ack), 0);
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                chk((k < 3 ? fl_req : fl_eop) == 1, "R5", "request held without ack", 0, 1);
                if (k < 3)
                    chk(fl_data == 2'((d >> (2*k)) & 6'h3), "R4", "data stable",
                        int'(fl_data), int'((d >> (2*k)) & 6'h3));
            end
            fl_ack = 1'b1;
            @(negedge clk);
            chk(fl_req == 0 && fl_eop == 0, "R5", "request drop after ack",
                int'({fl_req, fl_eop}), 0);
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                chk(fl_req == 0 && fl_eop == 0, "R5", "no request while ack high",
                    int'({fl_req, fl_eop}), 0);
            end
            fl_ack = 1'b0;
            @(negedge clk);
            if (k < 3) begin
                chk(fl_req == 0 && fl_eop == 0, "R6", "next request too early",
                    int'({fl_req, fl_eop}), 0);
                if (k < 2)
                    chk(fl_data == 2'((d >> (2*(k+1))) & 6'h3), "R4", "next flit ahead",
                        int'(fl_data), int'((d >> (2*(k+1))) & 6'h3));
                @(negedge clk);
            end else begin
                chk(up_ack == 1, "R8", "up_ack after eop", int'(up_ack), 1);
            end
        end
        for (int h = 0; h < 2; h++) begin
            @(negedge clk);
            chk(up_ack == 1 && fl_req == 0 && fl_eop == 0, "R9", "ack held, no new packet",
                int'({up_ack, fl_req, fl_eop}), 4);
        end
        up_req = 1'b0;
        @(negedge clk);
        chk(up_ack == 0, "R9", "up_ack release", int'(up_ack), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_idle_ack();
        send_packet(6'b10_01_11, 0);
        send_packet(6'b01_11_00, 2);
        send_packet(6'h3F, 1);
        send_packet(6'h00, 3);
        @(negedge clk);
        send_packet(6'b11_00_10, 0);
        test_idle_ack();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule